// File: doc/BRIEF.md
# Flash Command Sequencer with Ready/Busy Output

This block models the device side of a parallel NOR flash command port. Each one-cycle write strobe, with its address and data byte, stands for one write-enable pulse. The block follows the multi-cycle unlock-and-command sequences and decides when an embedded program or erase begins. It then drives an active-high ready output and reports the current operating mode.

Any write that breaks a sequence makes the block drop that partial sequence. An embedded operation runs until the completion input arrives. While an erase is running, it can be suspended and later resumed, and ready is high during the suspension.

Two inputs override everything else. The reset input holds the block busy and in read mode for as long as it is high. The supply-lockout input forces read mode and discards every write while it is active. The memory array, the algorithm timing and the pin's electrical behaviour are modelled elsewhere.

Top module: `flash_busy_ctl`

## Requirements
- R1: `mode` encodes the operating mode as 2'b00 read, 2'b01 programming, 2'b10 erasing and 2'b11 erase-suspended. While `hw_rst` is high, `ready` is 0 and `mode` is read. After `hw_rst` falls, `mode` is read and `ready` is 1.
- R2: From read mode, the write sequence AA@555, 55@2AA, A0@555, then a fourth write with any address and data, enters programming. `ready` goes low and `mode` shows 2'b01 in the cycle after the fourth strobe, and not earlier.
- R3: From read mode, the writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA enter erasing on a sixth write, which is either 10@555 or 30 at any address. `ready` goes low in the cycle after the sixth strobe.
- R4: A write whose address/data pair does not match the expected step ends the partial sequence. That write is not counted as the start of a new sequence, `mode` stays read and `ready` stays 1.
- R5: `op_done` in programming or erasing returns the block to read mode with `ready` at 1 in the next cycle. If `op_done` and a B0 write arrive in the same cycle while erasing, `op_done` wins. `op_done` has no effect in read or erase-suspended mode.
- R6: While erasing, a write with data B0 at any address enters erase-suspended mode, and `ready` is 1. While suspended, a write with data 30 at any address resumes erasing, and `ready` is 0.
- R7: While `lockout` is high, the block returns to read mode in the next cycle, any partial sequence is discarded, and every write is ignored. Only a full sequence started after `lockout` falls starts an operation.
- R8: While programming, all writes are ignored. While erasing, writes other than B0 are ignored. While suspended, writes other than 30 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Asynchronous reset input, active high; busy while high |
| lockout | input | 1 | Supply-lockout condition, active high |
| wr_stb | input | 1 | One-cycle write pulse |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data byte |
| op_done | input | 1 | Embedded program/erase finished |
| ready | output | 1 | 1 = ready, 0 = busy |
| mode | output | 2 | Current operating mode |

## Verification
The assertions check several rules on every cycle:
- lockout always lands the block in read mode with no sequence pending;
- programming is only ever entered on the clock after an accepted write;
- suspension is only entered from erasing;
- completion always returns a running operation to read mode.

Other behaviour only the bench scenarios can show:
- that busy waits for exactly the fourth or sixth pulse;
- that a wrong pair at each unlock step aborts the sequence;
- that stray writes and stray completions leave the mode untouched.

// File: rtl/flash_busy_ctl.sv
module flash_busy_ctl #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic              lockout,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_done,
  output logic              ready,
  output logic [1:0]        mode
);

  typedef enum logic [1:0] {M_READ = 2'b00, M_PROG = 2'b01, M_ERASE = 2'b10, M_SUSP = 2'b11} mode_t;
  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PARM, S_ESET, S_EU1, S_EU2} step_t;

  localparam logic [ADDR_W-1:0] A_FIRST  = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] A_SECOND = ADDR_W'(12'h2AA);
  localparam logic [DATA_W-1:0] D_KEY1   = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] D_KEY2   = DATA_W'(8'h55);
  localparam logic [DATA_W-1:0] D_PROG   = DATA_W'(8'hA0);
  localparam logic [DATA_W-1:0] D_ESETUP = DATA_W'(8'h80);
  localparam logic [DATA_W-1:0] D_CHIP   = DATA_W'(8'h10);
  localparam logic [DATA_W-1:0] D_SECT   = DATA_W'(8'h30);
  localparam logic [DATA_W-1:0] D_SUSP   = DATA_W'(8'hB0);

  mode_t cur, cur_nx;
  step_t step, step_nx;

  wire at_first  = wr_addr == A_FIRST;
  wire key1      = at_first && wr_data == D_KEY1;
  wire key2      = (wr_addr == A_SECOND) && wr_data == D_KEY2;
  wire erase_go  = (at_first && wr_data == D_CHIP) || wr_data == D_SECT;
  wire wr_ok     = wr_stb && !lockout;

  always_comb begin
    cur_nx  = cur;
    step_nx = step;
    if (lockout) begin
      cur_nx  = M_READ;
      step_nx = S_IDLE;
    end else begin
      unique case (cur)
        M_READ: if (wr_stb) begin
          step_nx = S_IDLE;
          unique case (step)
            S_IDLE: if (key1) step_nx = S_U1;
            S_U1:   if (key2) step_nx = S_U2;
            S_U2: begin
              if (at_first && wr_data == D_PROG)   step_nx = S_PARM;
              if (at_first && wr_data == D_ESETUP) step_nx = S_ESET;
            end
            S_PARM: cur_nx = M_PROG;
            S_ESET: if (key1) step_nx = S_EU1;
            S_EU1:  if (key2) step_nx = S_EU2;
            S_EU2:  if (erase_go) cur_nx = M_ERASE;
            default: step_nx = S_IDLE;
          endcase
        end
        M_PROG:  if (op_done) cur_nx = M_READ;
        M_ERASE: begin
          if (op_done) cur_nx = M_READ;
          else if (wr_stb && wr_data == D_SUSP) cur_nx = M_SUSP;
        end
        M_SUSP:  if (wr_stb && wr_data == D_SECT) cur_nx = M_ERASE;
        default: cur_nx = M_READ;
      endcase
    end
  end

  always_ff @(posedge clk or posedge hw_rst) begin
    if (hw_rst) begin
      cur  <= M_READ;
      step <= S_IDLE;
    end else begin
      cur  <= cur_nx;
      step <= step_nx;
    end
  end

  assign mode  = cur;
  assign ready = !hw_rst && (cur == M_READ || cur == M_SUSP);

  // R7
  lock_forces_read_chk: assert property (@(posedge clk) disable iff (hw_rst)
    lockout |=> (cur == M_READ && step == S_IDLE));

  // R2
  prog_needs_write_chk: assert property (@(posedge clk) disable iff (hw_rst)
    $rose(cur == M_PROG) |-> $past(wr_ok && step == S_PARM));

  // R6
  susp_from_erase_chk: assert property (@(posedge clk) disable iff (hw_rst)
    $rose(cur == M_SUSP) |-> $past(cur == M_ERASE));

  // R5
  done_to_read_chk: assert property (@(posedge clk) disable iff (hw_rst)
    (op_done && !lockout && (cur == M_PROG || cur == M_ERASE)) |=> cur == M_READ);

  // R8
  busy_no_step_chk: assert property (@(posedge clk) disable iff (hw_rst)
    (cur != M_READ) |-> step == S_IDLE);

endmodule

// File: tb/test_flash_busy_ctl.sv
module test_flash_busy_ctl;
  logic clk = 0, hw_rst = 1, lockout = 0, wr_stb = 0, op_done = 0;
  logic [11:0] wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic ready;
  logic [1:0] mode;
  int total = 0, bad = 0;
  int m_mode = 0;
  logic [19:0] hist[$];

  always #5 clk = ~clk;

  flash_busy_ctl i_flash_busy_ctl (.clk(clk), .hw_rst(hw_rst), .lockout(lockout), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .op_done(op_done), .ready(ready), .mode(mode));

  function automatic bit fits(logic [19:0] e, int i, bit erase);
    logic [11:0] a = e[19:8];
    logic [7:0]  d = e[7:0];
    case (i)
      0: return a == 12'h555 && d == 8'hAA;
      1: return a == 12'h2AA && d == 8'h55;
      2: return a == 12'h555 && d == (erase ? 8'h80 : 8'hA0);
      3: return erase ? (a == 12'h555 && d == 8'hAA) : 1'b1;
      4: return a == 12'h2AA && d == 8'h55;
      default: return (a == 12'h555 && d == 8'h10) || d == 8'h30;
    endcase
  endfunction

  function automatic bit prefix(bit erase);
    if (!erase && hist.size() > 4) return 0;
    foreach (hist[i]) if (!fits(hist[i], i, erase)) return 0;
    return 1;
  endfunction

  task automatic model_step();
    if (hw_rst || lockout) begin m_mode = 0; hist.delete(); end
    else case (m_mode)
      1: if (op_done) m_mode = 0;
      2: if (op_done) m_mode = 0; else if (wr_stb && wr_data == 8'hB0) m_mode = 3;
      3: if (wr_stb && wr_data == 8'h30) m_mode = 2;
      default: if (wr_stb) begin
        hist.push_back({wr_addr, wr_data});
        if (prefix(0) && hist.size() == 4) begin m_mode = 1; hist.delete(); end
        else if (prefix(1) && hist.size() == 6) begin m_mode = 2; hist.delete(); end
        else if (!prefix(0) && !prefix(1)) hist.delete();
      end
    endcase
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_step();
    #1;
    total++;
    if (ready !== (!hw_rst && (m_mode == 0 || m_mode == 3)) || mode !== 2'(m_mode)) begin
      bad++;
      $display("FAIL %s: ready=%0b mode=%0d expected ready=%0b mode=%0d", tag, ready, mode,
               !hw_rst && (m_mode == 0 || m_mode == 3), m_mode);
    end
    @(negedge clk);
    wr_stb = 0; op_done = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d, string tag);
    wr_stb = 1; wr_addr = a; wr_data = d;
    tick(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic done(string tag);
    op_done = 1;
    tick(tag);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    idle(3, "R1");
    hw_rst = 0;
    idle(2, "R1");
    // R2 program, busy only after fourth pulse
    wr(12'h555, 8'hAA, "R2"); wr(12'h2AA, 8'h55, "R2"); wr(12'h555, 8'hA0, "R2");
    wr(12'h123, 8'h5A, "R2"); idle(2, "R2");
    // R8 writes ignored in programming
    wr(12'h555, 8'hAA, "R8"); wr(12'h000, 8'hB0, "R8"); idle(1, "R8");
    done("R5"); idle(1, "R5");
    done("R5");
    // R3 chip erase
    wr(12'h555, 8'hAA, "R3"); wr(12'h2AA, 8'h55, "R3"); wr(12'h555, 8'h80, "R3");
    wr(12'h555, 8'hAA, "R3"); wr(12'h2AA, 8'h55, "R3"); wr(12'h555, 8'h10, "R3");
    wr(12'h040, 8'h77, "R8");
    // R6 suspend and resume
    wr(12'h040, 8'hB0, "R6"); idle(1, "R6");
    done("R5"); wr(12'h040, 8'h11, "R8");
    wr(12'h040, 8'h30, "R6"); idle(1, "R6");
    op_done = 1; wr(12'h040, 8'hB0, "R5");
    // R3 sector erase at arbitrary address
    wr(12'h555, 8'hAA, "R3"); wr(12'h2AA, 8'h55, "R3"); wr(12'h555, 8'h80, "R3");
    wr(12'h555, 8'hAA, "R3"); wr(12'h2AA, 8'h55, "R3"); wr(12'h7F0, 8'h30, "R3");
    done("R5");
    // R4 aborts at several steps
    wr(12'h555, 8'hAA, "R4"); wr(12'h555, 8'hAA, "R4"); wr(12'h2AA, 8'h55, "R4");
    wr(12'h555, 8'hA0, "R4"); wr(12'h100, 8'h01, "R4"); idle(1, "R4");
    wr(12'h555, 8'hAA, "R4"); wr(12'h2AA, 8'h55, "R4"); wr(12'h555, 8'h90, "R4");
    wr(12'h100, 8'h01, "R4");
    wr(12'h555, 8'hAA, "R4"); wr(12'h2AA, 8'h55, "R4"); wr(12'h555, 8'h80, "R4");
    wr(12'h555, 8'hAA, "R4"); wr(12'h2AB, 8'h55, "R4"); wr(12'h555, 8'h10, "R4");
    wr(12'h555, 8'hAA, "R4"); wr(12'h2AA, 8'h55, "R4"); wr(12'h555, 8'h80, "R4");
    wr(12'h555, 8'hAA, "R4"); wr(12'h2AA, 8'h55, "R4"); wr(12'h554, 8'h10, "R4");
    // R7 lockout discards partial sequence and writes
    wr(12'h555, 8'hAA, "R7"); wr(12'h2AA, 8'h55, "R7");
    lockout = 1;
    wr(12'h555, 8'hA0, "R7"); wr(12'h100, 8'h22, "R7");
    lockout = 0;
    wr(12'h100, 8'h22, "R7"); idle(1, "R7");
    wr(12'h555, 8'hAA, "R2"); wr(12'h2AA, 8'h55, "R2"); wr(12'h555, 8'hA0, "R2");
    wr(12'h200, 8'h33, "R2");
    lockout = 1; idle(1, "R7"); lockout = 0; idle(1, "R7");
    // R1 reset during operation
    wr(12'h555, 8'hAA, "R1"); wr(12'h2AA, 8'h55, "R1"); wr(12'h555, 8'hA0, "R1");
    wr(12'h200, 8'h33, "R1");
    hw_rst = 1; idle(2, "R1"); hw_rst = 0; idle(2, "R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule